// File: doc/BRIEF.md
# Pipelined Hazard Scoreboard

This block keeps an in-order record of the destination registers belonging to instructions that have left decode but have not yet written back. A decode stage presents the two source operand indices and the destination index of the instruction it holds. It stalls that instruction when any of the three indices matches an outstanding record. This check covers read-after-write and write-after-write hazards.

Each issued instruction places one record, and each writeback retires the oldest record. Writebacks return in issue order, so removal takes no argument. Squashed instructions still produce a writeback, with an invalid index, so the numbers of inserts and removes stay equal. Removal is applied ahead of search within a cycle: a register whose writeback is retired this cycle no longer stalls decode in that same cycle.

Top module: `hazard_sb`

## Requirements
- R1: Each of the three query ports (`qa`, `qb`, `qd`) raises its own hit output when its valid flag is high and its index equals the index of a live valid record. `stall` is the OR of the three hits.
- R2: A query whose valid flag is low never hits and never causes a stall, whatever its index.
- R3: When `ins_en` is high and `not_full` is high at a clock edge, the record {`ins_vld`, `ins_idx`} is stored. Search sees the new record from the next cycle onward and does not see it in the cycle of the insert.
- R4: When `rem_en` is high and the scoreboard is not empty, the oldest record is retired. Records leave in the order in which they were inserted.
- R5: A record retired in a cycle is already invisible to search in that same cycle.
- R6: A record inserted with `ins_vld` low takes a slot until it is removed, but it never matches any query.
- R7: `not_full` is low while `DEPTH` records are held, unless `rem_en` is high in the same cycle. An insert attempted while `not_full` is low is ignored.
- R8: `rem_en` on an empty scoreboard leaves the state unchanged.
- R9: A synchronous active-high `rst` empties the scoreboard, so that no query hits and `not_full` is high.
- R10: The capacity is the parameter `DEPTH`, with a default of 1. Register index width is `IDX_W`, with a default of 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ins_en | input | 1 | Record an issued instruction |
| ins_vld | input | 1 | Destination of the inserted record is valid |
| ins_idx | input | IDX_W | Destination index of the inserted record |
| rem_en | input | 1 | Retire the oldest record |
| qa_vld | input | 1 | First source query valid |
| qa_idx | input | IDX_W | First source query index |
| qb_vld | input | 1 | Second source query valid |
| qb_idx | input | IDX_W | Second source query index |
| qd_vld | input | 1 | Destination query valid |
| qd_idx | input | IDX_W | Destination query index |
| hit_a | output | 1 | First source query matches |
| hit_b | output | 1 | Second source query matches |
| hit_d | output | 1 | Destination query matches |
| stall | output | 1 | Any query matches |
| not_full | output | 1 | An insert would be accepted this cycle |

## Verification
Remove and search can fall in the same cycle, and so can remove and insert. The bench drives `rem_en` together with a query on the register held by the oldest record, and expects no hit in that cycle. It also drives `rem_en` together with `ins_en` while the scoreboard is full, and expects `not_full` to be high with the new record visible one cycle later. A reference queue in the bench applies remove, then search, then insert for every cycle and forms the expected hits and `not_full` from that order.

// File: rtl/hazard_sb.sv
module hazard_sb #(
  parameter int DEPTH = 1,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_en,
  input  logic             ins_vld,
  input  logic [IDX_W-1:0] ins_idx,
  input  logic             rem_en,
  input  logic             qa_vld,
  input  logic [IDX_W-1:0] qa_idx,
  input  logic             qb_vld,
  input  logic [IDX_W-1:0] qb_idx,
  input  logic             qd_vld,
  input  logic [IDX_W-1:0] qd_idx,
  output logic             hit_a,
  output logic             hit_b,
  output logic             hit_d,
  output logic             stall,
  output logic             not_full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0]    head, tail;
  logic [CW-1:0]    count;
  logic [DEPTH-1:0] busy, ent_v, live, m_a, m_b, m_d;
  logic [IDX_W-1:0] ent_idx [DEPTH];
  logic             rem_ok, ins_ok;

  assign rem_ok   = rem_en && (count != '0);
  assign not_full = (count != CW'(DEPTH)) || rem_ok;
  assign ins_ok   = ins_en && not_full;

  always_comb begin
    int t;
    t = int'(head) + int'(count);
    if (t >= DEPTH) t = t - DEPTH;
    tail = t[PW-1:0];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign live[i] = busy[i] && ent_v[i] && !(rem_ok && head == PW'(i));
    assign m_a[i]  = live[i] && ent_idx[i] == qa_idx;
    assign m_b[i]  = live[i] && ent_idx[i] == qb_idx;
    assign m_d[i]  = live[i] && ent_idx[i] == qd_idx;

    always_ff @(posedge clk) begin
      if (rst) begin
        busy[i]    <= 1'b0;
        ent_v[i]   <= 1'b0;
        ent_idx[i] <= '0;
      end else if (ins_ok && tail == PW'(i)) begin
        busy[i]    <= 1'b1;
        ent_v[i]   <= ins_vld;
        ent_idx[i] <= ins_idx;
      end else if (rem_ok && head == PW'(i)) begin
        busy[i]    <= 1'b0;
      end
    end
  end

  assign hit_a = qa_vld && (|m_a);
  assign hit_b = qb_vld && (|m_b);
  assign hit_d = qd_vld && (|m_d);
  assign stall = hit_a || hit_b || hit_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      count <= '0;
    end else begin
      if (rem_ok) head <= (head == PW'(DEPTH - 1)) ? '0 : head + PW'(1);
      count <= count + CW'(ins_ok) - CW'(rem_ok);
    end
  end
endmodule

// File: rtl/hazard_sb_chk.sv
module hazard_sb_chk #(
  parameter int DEPTH = 1,
  parameter int PW    = 1,
  parameter int CW    = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          ins_en,
  input logic          rem_en,
  input logic          qa_vld,
  input logic          qb_vld,
  input logic          qd_vld,
  input logic          stall,
  input logic          not_full,
  input logic [PW-1:0] head,
  input logic [CW-1:0] count
);
  // R2
  no_invalid_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (!qa_vld && !qb_vld && !qd_vld) |-> !stall);

  // R7
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(DEPTH) && !rem_en) |-> !not_full);

  // R7
  blocked_ins_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_en && !not_full) |=> count == CW'(DEPTH));

  // R8
  empty_rem_chk: assert property (@(posedge clk) disable iff (rst)
    (rem_en && !ins_en && count == '0) |=> (count == '0 && $stable(head)));

  // R1
  empty_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> !stall);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R9
  reset_empty_chk: assert property (@(posedge clk)
    rst |=> (count == '0 && not_full));
endmodule

bind hazard_sb hazard_sb_chk #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .ins_en(ins_en), .rem_en(rem_en),
  .qa_vld(qa_vld), .qb_vld(qb_vld), .qd_vld(qd_vld),
  .stall(stall), .not_full(not_full), .head(head), .count(count)
);

// File: tb/test_hazard_sb.sv
module test_hazard_sb;
  localparam int CLK_T = 10;
  localparam int D     = 3;
  localparam int W     = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ins_en = 0, ins_vld = 0, rem_en = 0;
  logic qa_vld = 0, qb_vld = 0, qd_vld = 0;
  logic [W-1:0] ins_idx = '0, qa_idx = '0, qb_idx = '0, qd_idx = '0;
  logic hit_a, hit_b, hit_d, stall, not_full;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [W:0]  model_q[$];
  logic [4:0]  exp_q[$];
  string       tag_q[$];

  always #(CLK_T/2) clk = ~clk;

  hazard_sb #(.DEPTH(D), .IDX_W(W)) i_hazard_sb (
    .clk(clk), .rst(rst), .ins_en(ins_en), .ins_vld(ins_vld), .ins_idx(ins_idx),
    .rem_en(rem_en), .qa_vld(qa_vld), .qa_idx(qa_idx), .qb_vld(qb_vld),
    .qb_idx(qb_idx), .qd_vld(qd_vld), .qd_idx(qd_idx), .hit_a(hit_a),
    .hit_b(hit_b), .hit_d(hit_d), .stall(stall), .not_full(not_full)
  );

  function automatic bit seen(bit v, logic [W-1:0] idx, bit drop);
    for (int k = (drop ? 1 : 0); k < model_q.size(); k++)
      if (v && model_q[k][W] && model_q[k][W-1:0] == idx) return 1;
    return 0;
  endfunction

  task automatic step(string tag, bit ie, bit iv, int ii, bit re,
                      bit av, int ai, bit bv, int bi, bit dv, int di);
    bit rok, nf, ha, hb, hd;
    @(negedge clk);
    ins_en = ie; ins_vld = iv; ins_idx = W'(ii); rem_en = re;
    qa_vld = av; qa_idx = W'(ai); qb_vld = bv; qb_idx = W'(bi);
    qd_vld = dv; qd_idx = W'(di);
    rok = re && model_q.size() > 0;
    nf  = model_q.size() < D || rok;
    ha  = seen(av, W'(ai), rok);
    hb  = seen(bv, W'(bi), rok);
    hd  = seen(dv, W'(di), rok);
    exp_q.push_back({ha, hb, hd, ha | hb | hd, nf});
    tag_q.push_back(tag);
    if (rok) void'(model_q.pop_front());
    if (ie && nf) model_q.push_back({iv, W'(ii)});
  endtask

  task automatic q(string tag, int a);
    step(tag, 0, 0, 0, 0, 1, a, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; ins_en = 0; rem_en = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    model_q.delete();
  endtask

  always @(negedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [4:0] e, got;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      got = {hit_a, hit_b, hit_d, stall, not_full};
      checks++;
      if (got !== e) begin
        errors++;
        $display("FAIL %s: hits/stall/not_full got %b expected %b", t, got, e);
      end
    end
  end

  initial begin
    #(CLK_T * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9: empty after reset
    step("R9", 0, 0, 0, 0, 1, 1, 1, 2, 1, 3);
    // R3: insert not visible in the same cycle
    step("R3", 1, 1, 5, 0, 1, 5, 0, 0, 0, 0);
    // R1: each port hits independently
    step("R1", 0, 0, 0, 0, 1, 5, 0, 0, 0, 0);
    step("R1", 0, 0, 0, 0, 0, 0, 1, 5, 0, 0);
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 1, 5);
    step("R1", 0, 0, 0, 0, 1, 4, 1, 5, 1, 6);
    // R2: invalid query with matching index
    step("R2", 0, 0, 0, 0, 0, 5, 0, 5, 0, 5);
    step("R3", 1, 1, 7, 0, 0, 0, 0, 0, 0, 0);
    // R6: invalid destination takes a slot
    step("R6", 1, 0, 7, 0, 1, 7, 0, 0, 0, 0);
    // R7: full, insert blocked
    step("R7", 1, 1, 9, 0, 1, 9, 0, 0, 0, 0);
    q("R7", 9);
    // R5: removal seen by search in the same cycle
    step("R5", 0, 0, 0, 1, 1, 5, 0, 0, 1, 7);
    // R4: oldest gone, next remains
    step("R4", 0, 0, 0, 0, 1, 5, 1, 7, 0, 0);
    step("R4", 1, 1, 9, 0, 0, 0, 0, 0, 0, 0);
    // R7: full, remove and insert in the same cycle
    step("R7", 1, 1, 11, 1, 1, 7, 0, 0, 0, 0);
    // R6: invalid record never matches its index
    step("R6", 0, 0, 0, 0, 1, 7, 1, 11, 1, 9);
    step("R4", 0, 0, 0, 1, 1, 9, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 1, 1, 9, 1, 11, 0, 0);
    step("R4", 0, 0, 0, 1, 1, 11, 0, 0, 0, 0);
    // R8: remove on empty ignored
    step("R8", 0, 0, 0, 1, 1, 11, 0, 0, 0, 0);
    step("R8", 1, 1, 4, 0, 0, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 1, 4, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 1, 1, 4, 0, 0, 0, 0);
    q("R8", 4);
    // R10: fill to DEPTH with wrapped pointers
    for (int k = 0; k < D + 1; k++) step("R10", 1, 1, 20 + k, 0, 1, 20, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 1, 22, 1, 23, 0, 0);
    for (int k = 0; k < D; k++) step("R4", 0, 0, 0, 1, 1, 21, 1, 22, 0, 0);
    step("R3", 1, 1, 30, 0, 0, 0, 0, 0, 0, 0);
    step("R3", 1, 1, 31, 0, 0, 0, 0, 0, 0, 0);
    // R9: reset mid-run clears records
    do_reset();
    step("R9", 0, 0, 0, 0, 1, 30, 1, 31, 1, 30);
    @(negedge clk);
    #4;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule